// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block is the timing core of a master for an open-drain, single-wire serial bus. It creates the bus reset pulse, checks for a presence response after that pulse, and runs single-bit write and read time slots. Each operation can run at standard speed or at overdrive speed. All durations are counted in microseconds from a one-clock enable tick (`usTick`), so the block does not depend on the system clock frequency. Each speed has its own set of parameters for the reset and slot windows.

A host starts an operation by presenting a command with `cmdValid` high while `busy` is low. The block latches the operation, the data bit and the speed select. It then drives `busPullLow` to pull the line low, and later releases it. The line is read back through a two-flop synchronizer. When the operation ends, `busy` falls and `done` pulses. The sampled presence result and the sampled read bit stay on their outputs until a later operation of the same kind replaces them. Byte assembly and command sequencing belong to the logic that drives this block.

Top module: `swb_master`

## Requirements
- R1: After reset, `busy`, `done`, `busPullLow`, `presence` and `readBit` are all 0.
- R2: A bus reset (`cmdOp` = 2'b01) pulls the line low for exactly 480 ticks at standard speed and 48 ticks at overdrive speed. `busy` stays high for 960 ticks at standard speed and 96 ticks at overdrive speed, counted from the first tick after acceptance.
- R3: During a bus reset, the line is sampled on the 70th tick (standard) or the 8th tick (overdrive) after release. `presence` becomes 1 if the synchronized line was low at that sample, and 0 otherwise.
- R4: A write slot (`cmdOp` = 2'b10) pulls the line low for 6 ticks (standard) or 1 tick (overdrive) when `cmdBit` = 1. It pulls the line low for 60 ticks (standard) or 8 ticks (overdrive) when `cmdBit` = 0. A slot plus its recovery keeps `busy` high for 75 ticks (standard) or 12 ticks (overdrive).
- R5: A read slot (`cmdOp` = 2'b11) pulls the line low for the write-one low time. It then releases the line, samples the synchronized line on the 15th tick (standard) or the 2nd tick (overdrive) after the falling edge, and stores that level in `readBit`. Its `busy` length is the same as for a write slot.
- R6: A command with `cmdOp` = 2'b00, or any command presented while `busy` is high, is ignored. It does not start an operation and does not change a running one.
- R7: `done` is high for exactly one clock when an operation finishes, in the first cycle in which `busy` is low. `done` never occurs together with `busy`.
- R8: The speed is taken from `overdrive` in the cycle the command is accepted. A change of `overdrive` during an operation has no effect on that operation.
- R9: `busLineIn` passes through a two-flop synchronizer before any sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-clock enable, once per microsecond |
| overdrive | input | 1 | 1 selects overdrive speed for the next command |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 00 none, 01 bus reset, 10 write bit, 11 read bit |
| cmdBit | input | 1 | Bit value for a write slot |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock pulse when an operation ends |
| presence | output | 1 | Result of the last presence sample |
| readBit | output | 1 | Result of the last read slot |
| busPullLow | output | 1 | 1 enables the open-drain pull-down |
| busLineIn | input | 1 | Line level from the bus |

## Verification
The bench sweeps the start of a simulated presence pulse across every tick near the sample point at overdrive speed, and in coarse steps at standard speed. This shows whether the sample falls on the exact tick, rather than one tick early or late. The read slot is swept the same way: a responder holds the line low for each possible number of ticks, so that the boundary where `readBit` changes from 0 to 1 shows the sample tick together with the synchronizer delay. Writes of both bit values at both speeds measure the low and busy times, which separates the write-one and write-zero timings and the two speed tables. Commands of kind none, commands issued while `busy` is high, and speed changes during an operation are each checked against the timing of an undisturbed operation.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOW  = 2'b01,
    ST_HIGH = 2'b10
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch command, clear elapsed counter
    logic run;       // count ticks
    logic sampleEn;  // line released, sampling allowed
  } strobe_t;

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);

  logic [STAGES-1:0] q;
  logic armed;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q[i] <= 1'b1;
          else       q[i] <= lineIn;
        end
        assert_sync_first_R9: assert property (@(posedge clk) disable iff (!rstN)
          armed |-> q[i] == $past(lineIn));
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q[i] <= 1'b1;
          else       q[i] <= q[i-1];
        end
        assert_sync_chain_R9: assert property (@(posedge clk) disable iff (!rstN)
          armed |-> q[i] == $past(q[i-1]));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign lineOut = q[STAGES-1];

endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic [1:0] cmdOp,
  input  logic      evLowEnd,
  input  logic      evFinish,
  output strobe_t   stb,
  output logic      pullLow,
  output logic      busy,
  output logic      done
);

  state_e state, stateNext;
  logic accept;

  assign accept = cmdValid && (state == ST_IDLE) && (cmdOp != OP_NOP);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept)   stateNext = ST_LOW;
      ST_LOW:  if (evLowEnd) stateNext = ST_HIGH;
      ST_HIGH: if (evFinish) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pullLow <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      pullLow <= (stateNext == ST_LOW);
      busy    <= (stateNext != ST_IDLE);
      done    <= (state == ST_HIGH) && evFinish;
    end
  end

  always_comb begin
    stb.load     = accept;
    stb.run      = (state != ST_IDLE);
    stb.sampleEn = (state == ST_HIGH);
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_low_in_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    pullLow |-> busy);

endmodule

// File: rtl/swb_datapath.sv
module swb_datapath
  import swb_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int STD_RST_LOW = 480,
  parameter int STD_RST_HI  = 480,
  parameter int STD_PRES    = 70,
  parameter int STD_W1L     = 6,
  parameter int STD_W0L     = 60,
  parameter int STD_SLOT    = 70,
  parameter int STD_RD      = 15,
  parameter int STD_REC     = 5,
  parameter int OD_RST_LOW  = 48,
  parameter int OD_RST_HI   = 48,
  parameter int OD_PRES     = 8,
  parameter int OD_W1L      = 1,
  parameter int OD_W0L      = 8,
  parameter int OD_SLOT     = 10,
  parameter int OD_RD       = 2,
  parameter int OD_REC      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  strobe_t    stb,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       overdrive,
  input  logic       lineSync,
  output logic       evLowEnd,
  output logic       evFinish,
  output logic       presence,
  output logic       readBit
);

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t S_RST_LOW = cnt_t'(STD_RST_LOW);
  localparam cnt_t S_RST_TOT = cnt_t'(STD_RST_LOW + STD_RST_HI);
  localparam cnt_t S_PRES_AT = cnt_t'(STD_RST_LOW + STD_PRES);
  localparam cnt_t S_W1L     = cnt_t'(STD_W1L);
  localparam cnt_t S_W0L     = cnt_t'(STD_W0L);
  localparam cnt_t S_RD_AT   = cnt_t'(STD_RD);
  localparam cnt_t S_SLOT_T  = cnt_t'(STD_SLOT + STD_REC);
  localparam cnt_t O_RST_LOW = cnt_t'(OD_RST_LOW);
  localparam cnt_t O_RST_TOT = cnt_t'(OD_RST_LOW + OD_RST_HI);
  localparam cnt_t O_PRES_AT = cnt_t'(OD_RST_LOW + OD_PRES);
  localparam cnt_t O_W1L     = cnt_t'(OD_W1L);
  localparam cnt_t O_W0L     = cnt_t'(OD_W0L);
  localparam cnt_t O_RD_AT   = cnt_t'(OD_RD);
  localparam cnt_t O_SLOT_T  = cnt_t'(OD_SLOT + OD_REC);

  op_e  opQ;
  logic bitQ;
  logic odQ;
  cnt_t elapsed, nextElapsed;
  cnt_t lowLen, sampleAt, totalLen;
  logic atTick, evSample;

  // command latch and elapsed-tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= OP_NOP;
      bitQ    <= 1'b0;
      odQ     <= 1'b0;
      elapsed <= '0;
    end else if (stb.load) begin
      opQ     <= op_e'(cmdOp);
      bitQ    <= cmdBit;
      odQ     <= overdrive;
      elapsed <= '0;
    end else if (atTick) begin
      elapsed <= nextElapsed;
    end
  end

  // window selection per operation and speed
  always_comb begin
    lowLen   = odQ ? O_W1L : S_W1L;
    sampleAt = '0;
    totalLen = odQ ? O_SLOT_T : S_SLOT_T;
    unique case (opQ)
      OP_RESET: begin
        lowLen   = odQ ? O_RST_LOW : S_RST_LOW;
        sampleAt = odQ ? O_PRES_AT : S_PRES_AT;
        totalLen = odQ ? O_RST_TOT : S_RST_TOT;
      end
      OP_WRITE: begin
        if (!bitQ) lowLen = odQ ? O_W0L : S_W0L;
      end
      OP_READ: begin
        sampleAt = odQ ? O_RD_AT : S_RD_AT;
      end
      default: ;
    endcase
  end

  assign atTick      = stb.run && usTick;
  assign nextElapsed = elapsed + cnt_t'(1);
  assign evLowEnd    = atTick && (nextElapsed == lowLen);
  assign evFinish    = atTick && (nextElapsed == totalLen);
  assign evSample    = atTick && stb.sampleEn && (opQ != OP_WRITE) &&
                       (nextElapsed == sampleAt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presence <= 1'b0;
      readBit  <= 1'b0;
    end else if (evSample) begin
      if (opQ == OP_RESET) presence <= !lineSync;
      else                 readBit  <= lineSync;
    end
  end

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.run |-> elapsed < totalLen);

  assert_presence_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(presence) |-> $past(opQ == OP_RESET && stb.sampleEn));

  assert_readbit_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readBit) |-> $past(opQ == OP_READ && stb.sampleEn));

  assert_speed_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.load) |=> $stable(odQ));

endmodule

// File: rtl/swb_master.sv
module swb_master #(
  parameter int SYNC_STAGES = 2,
  parameter int STD_RST_LOW = 480,
  parameter int STD_RST_HI  = 480,
  parameter int STD_PRES    = 70,
  parameter int STD_W1L     = 6,
  parameter int STD_W0L     = 60,
  parameter int STD_SLOT    = 70,
  parameter int STD_RD      = 15,
  parameter int STD_REC     = 5,
  parameter int OD_RST_LOW  = 48,
  parameter int OD_RST_HI   = 48,
  parameter int OD_PRES     = 8,
  parameter int OD_W1L      = 1,
  parameter int OD_W0L      = 8,
  parameter int OD_SLOT     = 10,
  parameter int OD_RD       = 2,
  parameter int OD_REC      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       overdrive,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       readBit,
  output logic       busPullLow,
  input  logic       busLineIn
);

  import swb_pkg::*;

  localparam int STD_MAX = (STD_RST_LOW + STD_RST_HI > STD_SLOT + STD_REC) ?
                           STD_RST_LOW + STD_RST_HI : STD_SLOT + STD_REC;
  localparam int OD_MAX  = (OD_RST_LOW + OD_RST_HI > OD_SLOT + OD_REC) ?
                           OD_RST_LOW + OD_RST_HI : OD_SLOT + OD_REC;
  localparam int MAX_TOT = (STD_MAX > OD_MAX) ? STD_MAX : OD_MAX;
  localparam int CNT_W   = $clog2(MAX_TOT + 1);

  strobe_t stb;
  logic lineSync, evLowEnd, evFinish;

  swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .lineIn(busLineIn), .lineOut(lineSync)
  );

  swb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .evLowEnd(evLowEnd), .evFinish(evFinish), .stb(stb),
    .pullLow(busPullLow), .busy(busy), .done(done)
  );

  swb_datapath #(
    .CNT_W(CNT_W),
    .STD_RST_LOW(STD_RST_LOW), .STD_RST_HI(STD_RST_HI), .STD_PRES(STD_PRES),
    .STD_W1L(STD_W1L), .STD_W0L(STD_W0L), .STD_SLOT(STD_SLOT),
    .STD_RD(STD_RD), .STD_REC(STD_REC),
    .OD_RST_LOW(OD_RST_LOW), .OD_RST_HI(OD_RST_HI), .OD_PRES(OD_PRES),
    .OD_W1L(OD_W1L), .OD_W0L(OD_W0L), .OD_SLOT(OD_SLOT),
    .OD_RD(OD_RD), .OD_REC(OD_REC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .stb(stb), .cmdOp(cmdOp),
    .cmdBit(cmdBit), .overdrive(overdrive), .lineSync(lineSync),
    .evLowEnd(evLowEnd), .evFinish(evFinish),
    .presence(presence), .readBit(readBit)
  );

  assert_start_accepted_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busPullLow) |-> $past(cmdValid) && !$past(busy));

endmodule

// File: tb/tb_swb_master.sv
`timescale 1ns/1ps
module tb_swb_master;

  localparam int S_RL = 480, S_RH = 480, S_PR = 70, S_W1 = 6, S_W0 = 60, S_SL = 75, S_RD = 15;
  localparam int O_RL = 48,  O_RH = 48,  O_PR = 8,  O_W1 = 1, O_W0 = 8,  O_SL = 12, O_RD = 2;

  logic clk = 1'b0, rstN = 1'b0, usTick = 1'b0, overdrive = 1'b0;
  logic cmdValid = 1'b0, cmdBit = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic busy, done, presence, readBit, busPullLow, busLineIn;
  logic slaveLow = 1'b0;

  int total = 0, bad = 0;
  int tickDiv = 0, opTicks = 0, lowTicks = 0, doneCnt = 0;
  int slvMode = 0, pStart = 0, pLen = 0, hold = 0, rstLowCur = 0;

  always #5 clk = ~clk;

  assign busLineIn = !busPullLow && !slaveLow;

  swb_master dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .overdrive(overdrive),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBit(cmdBit), .busy(busy),
    .done(done), .presence(presence), .readBit(readBit),
    .busPullLow(busPullLow), .busLineIn(busLineIn)
  );

  // tick generator, measurement counters and responder model
  always @(negedge clk) begin
    if (!rstN) begin
      tickDiv = 0;
      usTick  = 1'b0;
    end else begin
      tickDiv = (tickDiv + 1) % 4;
      usTick  = (tickDiv == 0);
      if (usTick && busy) opTicks++;
      if (usTick && busPullLow) lowTicks++;
      if (done) doneCnt++;
    end
    case (slvMode)
      1: slaveLow = busy && (opTicks >= rstLowCur + pStart) && (opTicks < rstLowCur + pStart + pLen);
      2: slaveLow = busy && (opTicks < hold);
      default: slaveLow = 1'b0;
    endcase
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic bitv, input logic od,
                       input bit poke, input bit flip);
    @(posedge clk); #2;
    cmdOp = op; cmdBit = bitv; overdrive = od; cmdValid = 1'b1;
    opTicks = 0; lowTicks = 0; doneCnt = 0;
    @(posedge clk); #2;
    cmdValid = 1'b0;
    if (flip) overdrive = !od;
    if (poke) begin
      repeat (20) @(posedge clk);
      #2; cmdValid = 1'b1; cmdOp = 2'b01; cmdBit = !bitv;
      @(posedge clk); #2; cmdValid = 1'b0;
    end
    while (busy) begin
      @(posedge clk); #2;
    end
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog act=busy exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 busPullLow", busPullLow, 0);
    chk("R1 presence", presence, 0);
    chk("R1 readBit", readBit, 0);
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R6 no-op command starts nothing
    begin
      int seen = 0;
      cmdOp = 2'b00; cmdValid = 1'b1;
      @(posedge clk); #2; cmdValid = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (busy || busPullLow) seen++;
        @(posedge clk); #2;
      end
      chk("R6 nop ignored", seen, 0);
    end

    // R2 reset timing, both speeds, no responder
    slvMode = 0;
    runOp(2'b01, 1'b0, 1'b0, 0, 0);
    chk("R2 std reset low", lowTicks, S_RL);
    chk("R2 std reset busy", opTicks, S_RL + S_RH);
    chk("R7 std reset done", doneCnt, 1);
    chk("R3 std no responder", presence, 0);
    runOp(2'b01, 1'b0, 1'b1, 0, 0);
    chk("R2 od reset low", lowTicks, O_RL);
    chk("R2 od reset busy", opTicks, O_RL + O_RH);
    chk("R3 od no responder", presence, 0);

    // R3 presence sweep, standard speed
    slvMode = 1; rstLowCur = S_RL; pLen = 45;
    for (int s = 0; s <= 80; s += 16) begin
      pStart = s;
      runOp(2'b01, 1'b0, 1'b0, 0, 0);
      chk($sformatf("R3 std presence start=%0d", s), presence,
          ((s <= S_PR - 1) && (S_PR - 1 < s + pLen)) ? 1 : 0);
    end
    // R3 presence sweep, overdrive, every start tick
    rstLowCur = O_RL; pLen = 3;
    for (int s = 0; s <= 12; s++) begin
      pStart = s;
      runOp(2'b01, 1'b0, 1'b1, 0, 0);
      chk($sformatf("R3 od presence start=%0d", s), presence,
          ((s <= O_PR - 1) && (O_PR - 1 < s + pLen)) ? 1 : 0);
    end
    slvMode = 0;

    // R4 write slots
    for (int od = 0; od < 2; od++) begin
      for (int b = 0; b < 2; b++) begin
        runOp(2'b10, b[0], od[0], 0, 0);
        chk($sformatf("R4 write low od=%0d bit=%0d", od, b), lowTicks,
            od ? (b ? O_W1 : O_W0) : (b ? S_W1 : S_W0));
        chk($sformatf("R4 write busy od=%0d bit=%0d", od, b), opTicks, od ? O_SL : S_SL);
        chk($sformatf("R7 write done od=%0d", od), doneCnt, 1);
      end
    end

    // R5 R9 read sweep: responder holds line low for 'hold' ticks
    slvMode = 2;
    for (int h = 0; h <= 24; h++) begin
      hold = h;
      runOp(2'b11, 1'b0, 1'b0, 0, 0);
      chk($sformatf("R5 R9 std read hold=%0d", h), readBit, (h <= S_RD - 1) ? 1 : 0);
      if (h == 0) begin
        chk("R5 std read low", lowTicks, S_W1);
        chk("R5 std read busy", opTicks, S_SL);
      end
    end
    for (int h = 0; h <= 5; h++) begin
      hold = h;
      runOp(2'b11, 1'b0, 1'b1, 0, 0);
      chk($sformatf("R5 R9 od read hold=%0d", h), readBit, (h <= O_RD - 1) ? 1 : 0);
      if (h == 0) chk("R5 od read low", lowTicks, O_W1);
    end
    slvMode = 0;

    // R6 command while busy ignored
    runOp(2'b10, 1'b1, 1'b0, 1, 0);
    chk("R6 busy poke low", lowTicks, S_W1);
    chk("R6 busy poke busy", opTicks, S_SL);
    chk("R6 busy poke done", doneCnt, 1);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (busy) seen++;
        @(posedge clk); #2;
      end
      chk("R6 no late start", seen, 0);
    end

    // R8 speed change mid-operation
    runOp(2'b10, 1'b0, 1'b0, 0, 1);
    chk("R8 std held low", lowTicks, S_W0);
    chk("R8 std held busy", opTicks, S_SL);
    runOp(2'b10, 1'b0, 1'b1, 0, 1);
    chk("R8 od held low", lowTicks, O_W0);
    chk("R8 od held busy", opTicks, O_SL);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule